// File: doc/BRIEF.md
# Timebase Predivider with Watchdog

This block generates the slow timing taps for a small controller. A fifteen-stage binary divider is driven by the base clock. Tap PHk, for k from 1 to 15, toggles each time tap PH(k-1) goes from high to low, so PHk has a period of 2^k base clocks. The five upper taps, PH11 to PH15, can be forced low without disturbing the lower ten. Software uses this to realign long intervals, and the same clearing happens on an external reset. A high-to-low transition of PH14 produces a one-cycle wake pulse, which is used to release a halted core.

A watchdog counts high-to-low transitions of PH10. After a fixed number of them it raises a one-clock reset request. The number is 8, 64 or 512 and is chosen by a parameter. Software sets and clears the enable flag and restarts the count with a clear strobe.

The enable flag is cleared by power-on reset and by external reset. A watchdog-caused reset does not clear it. For that reason the integrating chip must route the request to its core reset, and not back into `ext_rst`.

The design is one synchronous counter clocked by the base clock. Each bit changes on exactly the edges where the equivalent ripple stage would toggle.

Top module: `timebase_wdog`

## Requirements
- R1: Tap bus bit k-1 carries PHk. Outside reset and upper clearing, the tap bus, read as an unsigned number, increases by one on every clock and wraps from 2^15-1 to 0.
- R2: When `clr_upper` or `ext_rst` is high at a clock edge, taps bits 14..10 (PH11..PH15) are zero after that edge. Bits 9..0 still advance by one.
- R3: `halt_wake` is high for exactly the cycle in which tap bit 13 (PH14) first reads low after reading high, whether the tap reached zero by counting or by upper clearing. It is low in every other cycle.
- R4: With `WDT_SEL` = 0, 1 or 2, the watchdog fires on the 8th, 64th or 512th high-to-low transition of tap bit 9 (PH10). Transitions are counted since the later of enabling, the last clear strobe and the last firing. `wdt_req` is high in the same cycle that the tap shows the transition.
- R5: `wdt_req` lasts one clock. The count restarts from zero after it, so with no other stimulus the next request comes after another full interval.
- R6: `wdt_en_set` sets `wdt_en` and `wdt_en_clr` clears it. When both are high, clear wins. While `wdt_en` is low, no request is made and the count is held at zero.
- R7: A `wdt_kick` strobe restarts the count from zero.
- R8: Power-on reset and `ext_rst` clear `wdt_en` and the count. A watchdog firing leaves `wdt_en` set.
- R9: While `rst_n` is low, the taps, `halt_wake`, `wdt_req` and `wdt_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock PH0 |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst | input | 1 | External reset, synchronous, active high |
| clr_upper | input | 1 | One-cycle strobe forcing PH11..PH15 low |
| wdt_en_set | input | 1 | Strobe that enables the watchdog |
| wdt_en_clr | input | 1 | Strobe that disables the watchdog |
| wdt_kick | input | 1 | Strobe that restarts the watchdog count |
| taps | output | 15 | Divider taps, bit k-1 is PHk |
| halt_wake | output | 1 | One-cycle pulse on a PH14 high-to-low transition |
| wdt_req | output | 1 | One-cycle watchdog reset request |
| wdt_en | output | 1 | Watchdog enable flag |

## Verification
The hardest state to reach is a watchdog whose count is partly advanced at the moment a kick, a disable or an external reset arrives. The count itself is invisible, and each PH10 transition takes 1024 clocks. The bench runs the enabled watchdog through a known number of PH10 transitions, seen on the tap bus, and then applies the strobe. It places the strobe well away from a PH10 transition, so no count step shares the strobe's edge. It then checks whether the request comes after a full interval or earlier. A forced PH14 fall is reached by waiting for tap 13 to read high and then clearing the upper stages.

// File: rtl/timebase_wdog_pkg.sv
package timebase_wdog_pkg;

  // Watchdog interval in PH10 falls for each selector value.
  function automatic int unsigned wdt_span(input int unsigned sel);
    case (sel)
      0:       return 8;
      1:       return 64;
      default: return 512;
    endcase
  endfunction

  // Width needed to hold a count of 0 .. span-1.
  function automatic int unsigned wdt_count_width(input int unsigned span);
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

endpackage

// File: rtl/tbw_divider.sv
module tbw_divider #(
  parameter int unsigned STAGES    = 15,
  parameter int unsigned CLR_FIRST = 11,  // first clearable stage, 1-based
  parameter int unsigned WAKE_STG  = 14,  // stage whose fall wakes the core
  parameter int unsigned TICK_STG  = 10   // stage whose fall ticks the watchdog
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_upper,
  output logic [STAGES-1:0] taps,
  output logic              wake_fall,
  output logic              tick_fall
);
  localparam int unsigned CLR_LO = CLR_FIRST - 1;
  localparam int unsigned WAKE_B = WAKE_STG - 1;
  localparam int unsigned TICK_B = TICK_STG - 1;

  logic [STAGES-1:0] carry;  // stage input about to fall
  logic [STAGES-1:0] nxt;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i < STAGES - 1) begin : g_chain
      assign carry[i+1] = carry[i] & taps[i];
    end
    if (i >= CLR_LO) begin : g_upper
      assign nxt[i] = clr_upper ? 1'b0 : (taps[i] ^ carry[i]);
    end else begin : g_lower
      assign nxt[i] = taps[i] ^ carry[i];
    end
  end

  assign wake_fall = taps[WAKE_B] & ~nxt[WAKE_B];
  assign tick_fall = taps[TICK_B] & ~nxt[TICK_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= nxt;
  end

  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_upper |=> taps == STAGES'($past(taps) + 1'b1));

  a_r2_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr_upper |=> (taps[STAGES-1:CLR_LO] == '0) &&
                  (taps[CLR_LO-1:0] == CLR_LO'($past(taps[CLR_LO-1:0]) + 1'b1)));

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog
  import timebase_wdog_pkg::*;
#(
  parameter int unsigned SPAN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  input  logic tick,
  input  logic en_set,
  input  logic en_clr,
  input  logic kick,
  output logic en,
  output logic req
);
  localparam int unsigned CW = wdt_count_width(SPAN);
  localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

  logic [CW-1:0] cnt;
  logic          restart;   // count forced to zero this cycle
  logic          overflow;  // firing event

  assign restart  = ext_rst | en_clr | kick | ~en;
  assign overflow = ~restart & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
      req <= 1'b0;
    end else begin
      req <= overflow;
      if (ext_rst)     en <= 1'b0;
      else if (en_clr) en <= 1'b0;
      else if (en_set) en <= 1'b1;
      if (restart || overflow) cnt <= '0;
      else if (tick)           cnt <= cnt + CW'(1);
    end
  end

  a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  a_r6_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> en);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cnt == '0);

  a_r7_kick_zero: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt == '0);

  a_r8_flag_survives: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> en && req);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/timebase_wdog.sv
module timebase_wdog
  import timebase_wdog_pkg::*;
#(
  parameter int unsigned STAGES    = 15,
  parameter int unsigned CLR_FIRST = 11,
  parameter int unsigned WAKE_STG  = 14,
  parameter int unsigned TICK_STG  = 10,
  parameter int unsigned WDT_SEL   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              clr_upper,
  input  logic              wdt_en_set,
  input  logic              wdt_en_clr,
  input  logic              wdt_kick,
  output logic [STAGES-1:0] taps,
  output logic              halt_wake,
  output logic              wdt_req,
  output logic              wdt_en
);
  localparam int unsigned SPAN   = wdt_span(WDT_SEL);
  localparam int unsigned WAKE_B = WAKE_STG - 1;

  logic div_clr;
  logic wake_fall;
  logic tick_fall;

  assign div_clr = clr_upper | ext_rst;

  tbw_divider #(
    .STAGES(STAGES), .CLR_FIRST(CLR_FIRST),
    .WAKE_STG(WAKE_STG), .TICK_STG(TICK_STG)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .clr_upper(div_clr),
    .taps(taps), .wake_fall(wake_fall), .tick_fall(tick_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_wake <= 1'b0;
    else        halt_wake <= wake_fall;
  end

  tbw_watchdog #(.SPAN(SPAN)) u_wdt (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .tick(tick_fall),
    .en_set(wdt_en_set), .en_clr(wdt_en_clr), .kick(wdt_kick),
    .en(wdt_en), .req(wdt_req)
  );

  a_r3_wake_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    halt_wake |-> !taps[WAKE_B] && $past(taps[WAKE_B]));

  a_r3_fall_gives_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fall |=> halt_wake);

endmodule

// File: tb/test_timebase_wdog.sv
module test_timebase_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rst = 1'b0, clr_upper = 1'b0;
  logic        wdt_en_set = 1'b0, wdt_en_clr = 1'b0, wdt_kick = 1'b0;
  logic [14:0] taps;
  logic        halt_wake, wdt_req, wdt_en;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  timebase_wdog i_timebase_wdog (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .clr_upper(clr_upper),
    .wdt_en_set(wdt_en_set), .wdt_en_clr(wdt_en_clr), .wdt_kick(wdt_kick),
    .taps(taps), .halt_wake(halt_wake), .wdt_req(wdt_req), .wdt_en(wdt_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Move to a point where the next edge cannot be a PH10 fall.
  task automatic safe_point();
    while (taps[9:0] >= 10'd1000) cyc();
  endtask

  // Watch PH10 falls; expect a request on every `every`-th one (0 = never).
  task automatic watch(input int falls, input int every, input string req, output int fires);
    int   m = 0, seen = 0, mism = 0, a0 = 0, e0 = 0;
    logic p = taps[9];
    fires = 0;
    while (seen < falls) begin
      logic fell, exp;
      cyc();
      fell = p & ~taps[9];
      p    = taps[9];
      exp  = 1'b0;
      if (fell) begin
        seen++;
        if (every > 0) begin
          m++;
          if (m == every) begin exp = 1'b1; m = 0; end
        end
      end
      if (wdt_req !== exp) begin
        if (mism == 0) begin a0 = int'(wdt_req); e0 = int'(exp); end
        mism++;
      end
      if (wdt_req === 1'b1) fires++;
    end
    chk(mism == 0, req, a0, e0);
  endtask

  task automatic t_reset();
    chk(taps == 15'd0 && !halt_wake && !wdt_req && !wdt_en, "R9 reset state",
        int'({taps, halt_wake, wdt_req, wdt_en}), 0);
  endtask

  task automatic t_count();
    logic [14:0] prev = taps;
    int          mism = 0;
    for (int i = 0; i < 40; i++) begin
      cyc();
      if (taps !== prev + 15'd1) mism++;
      prev = taps;
    end
    chk(mism == 0, "R1 step by one", mism, 0);
    chk(taps == 15'd40, "R1 value after 40 clocks", int'(taps), 40);
  endtask

  task automatic t_upper_clear();
    logic [14:0] t, exp;
    while (taps[14:10] == 5'd0) cyc();
    t = taps;
    clr_upper = 1'b1;
    cyc();
    clr_upper = 1'b0;
    exp = (t + 15'd1) & 15'h03FF;
    chk(taps == exp, "R2 upper stages cleared", int'(taps), int'(exp));
    t = taps;
    cyc();
    chk(taps == t + 15'd1, "R1 counting after clear", int'(taps), int'(t + 15'd1));
  endtask

  task automatic t_wake_natural();
    logic p = taps[13];
    int   mism = 0, seen = 0, n = 0;
    while (seen == 0 && n < 40000) begin
      logic exp;
      cyc();
      n++;
      exp = p & ~taps[13];
      p   = taps[13];
      if (halt_wake !== exp) mism++;
      if (exp) seen++;
    end
    cyc();
    if (halt_wake !== 1'b0) mism++;
    chk(mism == 0 && seen == 1, "R3 wake on counted PH14 fall", mism, 0);
  endtask

  task automatic t_wake_forced();
    while (taps[13] == 1'b0) cyc();
    cyc();
    clr_upper = 1'b1;
    cyc();
    clr_upper = 1'b0;
    chk(halt_wake && !taps[13], "R3 wake on forced PH14 fall",
        int'({halt_wake, taps[13]}), 2);
    cyc();
    chk(!halt_wake, "R3 wake lasts one cycle", int'(halt_wake), 0);
  endtask

  task automatic t_wdt_basic();
    int fires;
    safe_point();
    wdt_en_set = 1'b1;
    cyc();
    wdt_en_set = 1'b0;
    chk(wdt_en, "R6 enable sets flag", int'(wdt_en), 1);
    watch(16, 8, "R4 request on 8th PH10 fall", fires);
    chk(fires == 2, "R5 one-cycle pulse and restart", fires, 2);
    chk(wdt_en, "R8 flag kept after firing", int'(wdt_en), 1);
  endtask

  task automatic t_wdt_kick();
    int fires;
    watch(5, 0, "R7 no request before kick", fires);
    safe_point();
    wdt_kick = 1'b1;
    cyc();
    wdt_kick = 1'b0;
    watch(8, 8, "R7 kick restarts count", fires);
  endtask

  task automatic t_wdt_disable();
    int fires;
    watch(4, 0, "R6 partial count", fires);
    safe_point();
    wdt_en_set = 1'b1;
    wdt_en_clr = 1'b1;
    cyc();
    wdt_en_set = 1'b0;
    wdt_en_clr = 1'b0;
    chk(!wdt_en, "R6 clear wins over set", int'(wdt_en), 0);
    watch(10, 0, "R6 no request while disabled", fires);
    safe_point();
    wdt_en_set = 1'b1;
    cyc();
    wdt_en_set = 1'b0;
    watch(8, 8, "R6 count held at zero while disabled", fires);
  endtask

  task automatic t_wdt_ext();
    int fires;
    watch(5, 0, "R8 partial count", fires);
    while (taps[14:10] == 5'd0) cyc();
    safe_point();
    ext_rst = 1'b1;
    cyc();
    ext_rst = 1'b0;
    chk(!wdt_en && taps[14:10] == 5'd0, "R8 external reset clears flag and upper taps",
        int'({wdt_en, taps[14:10]}), 0);
    watch(9, 0, "R8 no request after external reset", fires);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    t_count();
    t_upper_clear();
    t_wake_natural();
    t_wake_forced();
    t_wdt_basic();
    t_wdt_kick();
    t_wdt_disable();
    t_wdt_ext();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule